// File: doc/BRIEF.md
# Cascaded Integrator-Comb Decimation Filter

This block lowers the sample rate of a signed stream by an integer factor without a single multiplier. A chain of running-sum stages works at the input rate on every accepted sample. After every RATE-th accepted sample, the last running sum is handed to a chain of difference stages that works only at the low rate. The result is a low-pass, decimated stream whose DC gain is (RATE·DIFF_DELAY)^STAGES.

The input side has a new-sample strobe, a clock enable and a synchronous clear. All internal words are IN_W + STAGES·ceil(log2(RATE·DIFF_DELAY)) bits wide and use two's-complement wraparound. The intermediate sums may overflow, and the final differences are still exact. The low rate never uses a second clock: the decimated result is marked by a one-cycle valid pulse on the processing clock. When OUT_W is narrower than the internal width, the output is rounded half-up to OUT_W bits. Otherwise it is passed through at full precision. STAGES may be 3 to 6, DIFF_DELAY 1 or 2, RATE 4 to 8192, and OUT_W is at most 48 and at most the internal width.

Top module: `cic_decimator`

## Requirements
- R1: After rst_n is low, or after a cycle with clr high, out_valid is 0 and out_data is 0, and the accepted-sample count restarts from zero.
- R2: A sample is accepted only on a rising clock edge where both ce and in_valid are 1. Any other cycle leaves every later output unchanged, whatever in_data carries.
- R3: out_valid is high for exactly one cycle, in the cycle that follows every RATE-th accepted sample counted from reset or clear. It is never high on two consecutive cycles.
- R4: Call the accepted samples x[0], x[1], … and let s[n] be x summed STAGES times, cumulatively up to index n (s[n]=0 for n<0). Let u[j] = s[j·RATE+RATE−1−STAGES] (zero for j<0). The full-precision value reported with the j-th pulse (j from 0) is Σ_{i=0..STAGES} (−1)^i·C(STAGES,i)·u[j−(STAGES−1)−i·DIFF_DELAY].
- R5: A constant input c settles to c·(RATE·DIFF_DELAY)^STAGES at full precision. With the default parameters and c=1, out_data settles to 64.
- R6: Full-scale negative input held for hundreds of samples makes the running sums wrap, and the output still follows R4. With the defaults, −2048 settles to −131072.
- R7: With S = internal width − OUT_W, out_data = floor((full + 2^(S−1)) / 2^S). It equals the full value when S is 0.
- R8: When clr is high on the same cycle as the RATE-th accepted sample, the clear wins. No pulse follows, out_data becomes 0 and counting restarts.
- R9: While ce is 0, nothing advances, including the position inside the current group of RATE samples. This holds even when in_valid stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| clr | input | 1 | Synchronous clear of all filter state, acts regardless of ce |
| ce | input | 1 | Clock enable for all filter updates |
| in_valid | input | 1 | Marks in_data as a new sample |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | One-cycle pulse marking a new decimated result |
| out_data | output | OUT_W | Signed decimated result, full precision or rounded |

## Verification
The synchronous clear and the decimation strobe can fall in the same cycle. This happens when clr rises exactly on the sample that completes a group of RATE. The bench provokes it by tracking its own accepted-sample count and asserting clr with a valid sample on that boundary beat. It then requires that no valid pulse appears in the next cycle, that out_data reads 0, and that a fresh stream afterwards matches a freshly cleared reference model. A second overlap, ce dropping in the middle of a group while in_valid stays high, is judged by the exact alignment of all later results against the model.

// File: rtl/cic_pkg.sv
package cic_pkg;

  // smallest b with 2**b >= v
  function automatic int ceil_log2(input int v);
    int b;
    b = 0;
    while ((1 << b) < v) b++;
    return b;
  endfunction

  // bits of growth needed so that the difference chain never loses its result
  function automatic int growth_bits(input int stages, input int rate, input int dly);
    return stages * ceil_log2(rate * dly);
  endfunction

endpackage

// File: rtl/cic_integ.sv
module cic_integ #(
  parameter int W = 21
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] acc
);

  logic [W-1:0] acc_q;
  logic [W-1:0] acc_d;

  always_comb begin
    acc_d = acc_q;
    if (clr)     acc_d = '0;
    else if (en) acc_d = acc_q + din;   // wraps modulo 2**W on purpose
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;

  // R2: no accepted sample, no change of the running sum
  a_r2_integ_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(acc_q));

  // R8: a clear empties the running sum
  a_r8_integ_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0));

endmodule

// File: rtl/cic_phase.sv
module cic_phase #(
  parameter int RATE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic last
);

  localparam int PH_W = (RATE > 1) ? $clog2(RATE) : 1;
  localparam logic [PH_W-1:0] LAST_IDX = PH_W'(RATE - 1);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_d;

  always_comb begin
    ph_d = ph_q;
    if (clr) begin
      ph_d = '0;
    end else if (en) begin
      if (ph_q == LAST_IDX) ph_d = '0;
      else                  ph_d = ph_q + PH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign last = (ph_q == LAST_IDX);

  // R9: without an accepted sample the position in the group is frozen
  a_r9_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(ph_q));

  // R3: after the group boundary the count starts again at zero
  a_r3_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (en && last && !clr) |=> (ph_q == '0));

endmodule

// File: rtl/cic_comb.sv
module cic_comb #(
  parameter int W   = 21,
  parameter int DLY = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [DLY-1:0][W-1:0] line_q;
  logic [DLY-1:0][W-1:0] line_d;
  logic [W-1:0]          out_q;
  logic [W-1:0]          out_d;

  always_comb begin
    line_d = line_q;
    out_d  = out_q;
    if (clr) begin
      line_d = '0;
      out_d  = '0;
    end else if (en) begin
      out_d     = din - line_q[DLY-1];   // difference against DLY low-rate samples back
      line_d[0] = din;
      for (int i = 1; i < DLY; i++) line_d[i] = line_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      out_q  <= '0;
    end else begin
      line_q <= line_d;
      out_q  <= out_d;
    end
  end

  assign dout = out_q;

  // R4: differences move only on the low-rate strobe
  a_r4_comb_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> ($stable(out_q) && $stable(line_q)));

  // R8: a clear empties the difference stage
  a_r8_comb_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (out_q == '0));

endmodule

// File: rtl/cic_round.sv
module cic_round #(
  parameter int FULL_W = 21,
  parameter int OUT_W  = 18
) (
  input  logic [FULL_W-1:0] full,
  output logic [OUT_W-1:0]  rounded
);

  localparam int SHIFT = FULL_W - OUT_W;

  generate
    if (SHIFT == 0) begin : g_pass
      assign rounded = full;
    end else begin : g_round
      localparam logic [FULL_W-1:0] HALF = FULL_W'(1) << (SHIFT - 1);
      // round half up: add half an output LSB, then drop the low bits
      assign rounded = OUT_W'((full + HALF) >> SHIFT);
    end
  endgenerate

endmodule

// File: rtl/cic_decimator.sv
module cic_decimator #(
  parameter int IN_W       = 12,
  parameter int STAGES     = 3,
  parameter int RATE       = 8,
  parameter int DIFF_DELAY = 1,
  parameter int OUT_W      = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ce,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);

  localparam int ACC_W = IN_W + cic_pkg::growth_bits(STAGES, RATE, DIFF_DELAY);
  localparam int EXT_W = ACC_W - IN_W;

  logic accept;
  logic grp_last;
  logic strobe;
  logic vld_q;
  logic vld_d;

  logic [STAGES:0][ACC_W-1:0] integ_bus;
  logic [STAGES:0][ACC_W-1:0] comb_bus;

  assign accept = ce & in_valid;
  assign strobe = accept & grp_last;

  // sign extension into the internal word
  assign integ_bus[0] = {{EXT_W{in_data[IN_W-1]}}, in_data};

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_integ
      cic_integ #(.W(ACC_W)) u_integ (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .en    (accept),
        .din   (integ_bus[k]),
        .acc   (integ_bus[k+1])
      );
    end
  endgenerate

  cic_phase #(.RATE(RATE)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .en    (accept),
    .last  (grp_last)
  );

  // the difference chain samples the last running sum only on the strobe
  assign comb_bus[0] = integ_bus[STAGES];

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_comb
      cic_comb #(.W(ACC_W), .DLY(DIFF_DELAY)) u_comb (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .en    (strobe),
        .din   (comb_bus[k]),
        .dout  (comb_bus[k+1])
      );
    end
  endgenerate

  cic_round #(.FULL_W(ACC_W), .OUT_W(OUT_W)) u_round (
    .full    (comb_bus[STAGES]),
    .rounded (out_data)
  );

  // valid pulse is not held by ce: it lives exactly one cycle
  always_comb begin
    vld_d = strobe & ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign out_valid = vld_q;

  // R3: the pulse never lasts two cycles
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R8: a clear suppresses the pulse of the same cycle
  a_r8_clear_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !out_valid);

  // R9: no pulse follows a cycle without ce
  a_r9_no_pulse_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> !out_valid);

endmodule

// File: tb/cic_decimator_test.sv
module cic_decimator_test;

  localparam int CLK_PERIOD = 10;
  localparam int IN_W   = 12;
  localparam int STAGES = 3;
  localparam int RATE   = 8;
  localparam int DD     = 1;
  localparam int OUT_W  = 18;
  localparam int FULL_W = IN_W + STAGES * 3;   // log2(RATE*DD) = 3
  localparam int SHIFT  = FULL_W - OUT_W;
  localparam int HIST   = 8192;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n;
  logic clr;
  logic ce;
  logic in_valid;
  logic [IN_W-1:0]  in_data;
  logic             out_valid;
  logic [OUT_W-1:0] out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  cic_decimator #(
    .IN_W(IN_W), .STAGES(STAGES), .RATE(RATE), .DIFF_DELAY(DD), .OUT_W(OUT_W)
  ) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ce(ce), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_tag = "R4";

  // reference model state
  longint sums [STAGES];
  longint hist [HIST];
  int     nbeat;
  longint exp_q [$];
  string  tag_q [$];
  longint last_out;

  function automatic longint binom(input int n, input int k);
    longint r = 1;
    for (int i = 1; i <= k; i++) r = r * (n - k + i) / i;
    return r;
  endfunction

  function automatic longint low_sample(input int j);
    int b;
    if (j < 0) return 0;
    b = j * RATE + RATE - 1 - STAGES;
    if (b < 0) return 0;
    return hist[b];
  endfunction

  function automatic longint round_ref(input longint y);
    if (SHIFT == 0) return y;
    return (y + (longint'(1) <<< (SHIFT - 1))) >>> SHIFT;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < STAGES; k++) sums[k] = 0;
    nbeat = 0;
  endtask

  task automatic model_accept(input int x);
    longint y;
    int j;
    sums[0] += x;
    for (int k = 1; k < STAGES; k++) sums[k] += sums[k-1];
    if (nbeat < HIST) hist[nbeat] = sums[STAGES-1];
    if ((nbeat % RATE) == RATE - 1) begin
      j = nbeat / RATE;
      y = 0;
      for (int i = 0; i <= STAGES; i++) begin
        if (i % 2 == 0) y += binom(STAGES, i) * low_sample(j - (STAGES - 1) - i * DD);
        else            y -= binom(STAGES, i) * low_sample(j - (STAGES - 1) - i * DD);
      end
      exp_q.push_back(round_ref(y));
      tag_q.push_back(cur_tag);
    end
    nbeat++;
  endtask

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // driver: one cycle of stimulus, model updated in step
  task automatic beat(input bit v, input bit c, input bit k, input int x);
    @(negedge clk);
    in_valid = v;
    ce       = c;
    clr      = k;
    in_data  = x[IN_W-1:0];
    if (k)           model_reset();
    else if (v && c) model_accept(x);
  endtask

  task automatic do_clear();
    beat(1'b0, 1'b0, 1'b1, 0);   // clear acts without ce
    beat(1'b0, 1'b0, 1'b0, 0);
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) beat(1'b0, 1'b1, 1'b0, 0);
    check(exp_q.size() == 0, "R3 pending results", exp_q.size(), 0);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: pops the scoreboard on every result pulse
  always @(negedge clk) begin
    longint act;
    string t;
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      act = longint'($signed(out_data));
      last_out = act;
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected pulse", act, 0);
      end else begin
        t = tag_q.pop_front();
        check(act == exp_q[0], t, act, exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      check(1'b0, "R3 watchdog", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; ce = 1'b0; in_valid = 1'b0; in_data = '0;
    last_out = 0;
    model_reset();
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    check(out_data == '0, "R1 data in reset", longint'($signed(out_data)), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);

    // R7: impulse gives fractional results that exercise rounding
    cur_tag = "R7 impulse";
    beat(1'b1, 1'b1, 1'b0, 1);
    for (int i = 0; i < 6 * RATE; i++) beat(1'b1, 1'b1, 1'b0, 0);
    drain();

    // R4: continuous random stream
    do_clear();
    cur_tag = "R4 random";
    for (int i = 0; i < 400; i++) beat(1'b1, 1'b1, 1'b0, int'($urandom_range(0, 4095)) - 2048);
    drain();

    // R2: gaps with in_valid low, and with ce low
    do_clear();
    cur_tag = "R2 gaps";
    for (int i = 0; i < 500; i++) begin
      int sel = int'($urandom_range(0, 3));
      int x = int'($urandom_range(0, 4095)) - 2048;
      if (sel == 0)      beat(1'b0, 1'b1, 1'b0, x);
      else if (sel == 1) beat(1'b1, 1'b0, 1'b0, x);
      else               beat(1'b1, 1'b1, 1'b0, x);
    end
    drain();

    // R9: long ce-low stretches in the middle of a group, in_valid held high
    do_clear();
    cur_tag = "R9 ce hold";
    for (int g = 0; g < 30; g++) begin
      for (int i = 0; i < 5; i++) beat(1'b1, 1'b1, 1'b0, int'($urandom_range(0, 4095)) - 2048);
      for (int i = 0; i < 7; i++) begin
        beat(1'b1, 1'b0, 1'b0, 2047);
        check(out_valid == 1'b0 || i == 0, "R9 no pulse while ce low", out_valid, 0);
      end
    end
    drain();

    // R5: DC gain
    do_clear();
    cur_tag = "R5 dc";
    for (int i = 0; i < 12 * RATE; i++) beat(1'b1, 1'b1, 1'b0, 1);
    drain();
    check(last_out == 64, "R5 settled dc", last_out, 64);

    // R6: full-scale negative input, running sums wrap
    do_clear();
    cur_tag = "R6 wrap";
    for (int i = 0; i < 600; i++) beat(1'b1, 1'b1, 1'b0, -2048);
    drain();
    check(last_out == -131072, "R6 settled full scale", last_out, -131072);

    // R8: clear on the boundary sample
    do_clear();
    cur_tag = "R8 before";
    for (int i = 0; i < 3 * RATE + 2; i++) beat(1'b1, 1'b1, 1'b0, int'($urandom_range(0, 4095)) - 2048);
    while ((nbeat % RATE) != RATE - 1) beat(1'b1, 1'b1, 1'b0, 1000);
    beat(1'b1, 1'b1, 1'b1, 1500);
    beat(1'b0, 1'b1, 1'b0, 0);
    check(out_valid == 1'b0, "R8 no pulse after clear", out_valid, 0);
    check(out_data == '0, "R8 data cleared", longint'($signed(out_data)), 0);
    check(exp_q.size() == 0, "R8 nothing pending", exp_q.size(), 0);
    cur_tag = "R8 after";
    for (int i = 0; i < 10 * RATE; i++) beat(1'b1, 1'b1, 1'b0, int'($urandom_range(0, 4095)) - 2048);
    drain();

    // R1: clear returns outputs to zero
    beat(1'b0, 1'b1, 1'b1, 0);
    beat(1'b0, 1'b1, 1'b0, 0);
    check(out_data == '0, "R1 data after clear", longint'($signed(out_data)), 0);

    finish_run();
  end

endmodule